// File: doc/BRIEF.md
# Power Island Wake-Up Sequencer

This block powers up one switchable power island under hardware control. A single start pulse launches a fixed series of steps. Each step changes one part of the island's control word. The island's two switch stages are turned on one after the other. The block then waits for both power-good acknowledges. After that it releases the clock gate, the isolation clamps and the island reset, and finally powers up the island's SRAM banks. It then waits for the SRAM acknowledges to drop.

Each acknowledge wait is bounded by a cycle budget taken from an input port. If the budget runs out, the block reports an error, leaves the control word where it stopped and returns to idle. A later start resumes the sequence from that word. A successful run ends with a one-cycle done pulse. When the SRAM acknowledge mask parameter is zero, the SRAM wait is left out altogether.

The control word drives the island directly. A status port carries a copy of the same word for observation.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset the control word is 0xF12 (with SRAM_W=4): bit0 reset_n=0, bit1 isolation=1, bit2 primary enable=0, bit3 secondary enable=0, bit4 clock disable=1, bits 7..5=0, and the SRAM power-down field at bits 8 and up is all ones. The done and error outputs are low.
- R2: The edge that samples start_i in idle sets bit2. The following edge sets bit3. These are two separate cycles.
- R3: After both enables are set, the block waits until pwr_ack_i and pwr_ack2_i are both high. A single acknowledge does not advance the sequence.
- R4: Once power is acknowledged, the block takes four single-cycle steps, one per edge and in this order: it clears bit4, clears bit1, sets bit0, then clears the whole SRAM field.
- R5: With a nonzero ACK_MASK, done is given only after every sram_ack_i bit selected by ACK_MASK reads 0. Bits outside the mask (default mask 4'b1011) are ignored.
- R6: With ACK_MASK of zero the SRAM wait is skipped. Done is high in the cycle after the SRAM field clears, which is 6 edges after the start edge, counting the start edge. With a mask and the acknowledges already clear, this takes 7 edges.
- R7: Each wait checks its condition at most budget_i+1 times. A condition first met at the last check succeeds. If the condition is still unmet at that check, error pulses and the control word stays frozen. A power-wait timeout shows error B+3 edges after start. An SRAM-wait timeout shows error B+7 edges after start.
- R8: A start_i pulse while a sequence is running has no effect.
- R9: Done and error are one-cycle pulses and never high together. The block then returns to idle and accepts a new start, which continues from the current control word.
- R10: status_o always equals ctrl_o. Bits 7..5 of the word stay 0. At most one step's field changes per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the power-up sequence (sampled in idle) |
| budget_i | input | TMO_W | Cycle budget for each acknowledge wait |
| pwr_ack_i | input | 1 | Primary power-good acknowledge |
| pwr_ack2_i | input | 1 | Secondary power-good acknowledge |
| sram_ack_i | input | ACK_W | SRAM power-down acknowledges |
| ctrl_o | output | 8+SRAM_W | Island control word |
| status_o | output | 8+SRAM_W | Copy of the control word |
| done_o | output | 1 | One-cycle pulse on completion |
| err_o | output | 1 | One-cycle pulse on wait timeout |

## Verification
Some rules are checked by the assertions on every cycle. No cycle changes more than one step's field. Isolation falls only with the clock already enabled, reset rises only with isolation already off, and the SRAM field clears only with reset already released. The clock is released only after both power acknowledges were seen. Done and error are single, exclusive pulses, and done never follows a cycle with a masked SRAM acknowledge still high. Other behaviour can only be shown by the bench's scenarios. These are the exact order of words, the cycle counts to done and to error at the budget boundary, resuming after an error, the shorter path when the mask is empty, and starts that are ignored mid-run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int BIT_RSTN  = 0;
  localparam int BIT_ISO   = 1;
  localparam int BIT_EN1   = 2;
  localparam int BIT_EN2   = 3;
  localparam int BIT_CKOFF = 4;
  localparam int PDN_LSB   = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EN2, ST_WPWR, ST_CLK, ST_ISO, ST_RST, ST_SRAM, ST_WSRAM, ST_FIN, ST_ERR
  } seq_st_e;

  typedef struct packed {
    logic en1;
    logic en2;
    logic ck_on;
    logic iso_off;
    logic rst_rel;
    logic sram_on;
  } step_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] budget_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (cnt_q < budget_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= budget_i);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter bit SKIP_SRAM = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  pwr_ok_i,
  input  logic  sram_ok_i,
  input  logic  expired_i,
  output step_t step_o,
  output logic  run_o,
  output logic  done_o,
  output logic  err_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    step_o = '0;
    unique case (st_q)
      ST_IDLE:  if (start_i) begin st_d = ST_EN2; step_o.en1 = 1'b1; end
      ST_EN2:   begin st_d = ST_WPWR; step_o.en2 = 1'b1; end
      ST_WPWR:  if (pwr_ok_i) begin st_d = ST_ISO; step_o.ck_on = 1'b1; end
                else if (expired_i) st_d = ST_ERR;
      ST_ISO:   begin st_d = ST_RST; step_o.iso_off = 1'b1; end
      ST_RST:   begin st_d = ST_SRAM; step_o.rst_rel = 1'b1; end
      ST_SRAM:  begin st_d = SKIP_SRAM ? ST_FIN : ST_WSRAM; step_o.sram_on = 1'b1; end
      ST_WSRAM: if (sram_ok_i) st_d = ST_FIN;
                else if (expired_i) st_d = ST_ERR;
      ST_FIN:   st_d = ST_IDLE;
      ST_ERR:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign run_o  = (st_q == ST_WPWR) || (st_q == ST_WSRAM);
  assign done_o = (st_q == ST_FIN);
  assign err_o  = (st_q == ST_ERR);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SRAM_W = 4,
  localparam int CW    = PDN_LSB + SRAM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  step_t         step_i,
  output logic [CW-1:0] word_o
);
  // island held off: reset low, clamps on, switches off, clock gated, SRAM down
  localparam logic [CW-1:0] RST_WORD = {{SRAM_W{1'b1}}, 3'b000, 1'b1, 2'b00, 1'b1, 1'b0};

  logic [CW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RST_WORD;
    else begin
      if (step_i.en1)     word_q[BIT_EN1]   <= 1'b1;
      if (step_i.en2)     word_q[BIT_EN2]   <= 1'b1;
      if (step_i.ck_on)   word_q[BIT_CKOFF] <= 1'b0;
      if (step_i.iso_off) word_q[BIT_ISO]   <= 1'b0;
      if (step_i.rst_rel) word_q[BIT_RSTN]  <= 1'b1;
      if (step_i.sram_on) word_q[CW-1:PDN_LSB] <= '0;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pwr_seq_pkg::*;
#(
  parameter int                SRAM_W   = 4,
  parameter int                ACK_W    = 4,
  parameter logic [ACK_W-1:0]  ACK_MASK = 4'b1011,
  parameter int                TMO_W    = 8,
  localparam int               CW       = PDN_LSB + SRAM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMO_W-1:0] budget_i,
  input  logic             pwr_ack_i,
  input  logic             pwr_ack2_i,
  input  logic [ACK_W-1:0] sram_ack_i,
  output logic [CW-1:0]    ctrl_o,
  output logic [CW-1:0]    status_o,
  output logic             done_o,
  output logic             err_o
);
  localparam bit SKIP_SRAM = (ACK_MASK == '0);

  step_t step;
  logic  run, expired, sram_ok;

  generate
    if (SKIP_SRAM) begin : g_no_sram_wait
      assign sram_ok = 1'b1;
    end else begin : g_sram_wait
      assign sram_ok = ((sram_ack_i & ACK_MASK) == '0);
    end
  endgenerate

  pwr_seq_fsm #(.SKIP_SRAM(SKIP_SRAM)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .pwr_ok_i  (pwr_ack_i && pwr_ack2_i),
    .sram_ok_i (sram_ok),
    .expired_i (expired),
    .step_o    (step),
    .run_o     (run),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  pwr_seq_timer #(.TMO_W(TMO_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .budget_i  (budget_i),
    .expired_o (expired)
  );

  pwr_seq_ctrl #(.SRAM_W(SRAM_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .word_o (ctrl_o)
  );

  assign status_o = ctrl_o;
endmodule

// File: rtl/pwr_island_seq_chk.sv
module pwr_island_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int               SRAM_W   = 4,
  parameter int               ACK_W    = 4,
  parameter logic [ACK_W-1:0] ACK_MASK = 4'b1011,
  localparam int              CW       = PDN_LSB + SRAM_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_ack_i,
  input logic             pwr_ack2_i,
  input logic [ACK_W-1:0] sram_ack_i,
  input logic [CW-1:0]    ctrl_o,
  input logic             done_o,
  input logic             err_o
);
  logic [CW-1:0] prev_q;
  logic          vld_q;
  logic [5:0]    chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin prev_q <= '0; vld_q <= 1'b0; end
    else begin prev_q <= ctrl_o; vld_q <= 1'b1; end
  end

  assign chg = {ctrl_o[BIT_RSTN]  != prev_q[BIT_RSTN],
                ctrl_o[BIT_ISO]   != prev_q[BIT_ISO],
                ctrl_o[BIT_EN1]   != prev_q[BIT_EN1],
                ctrl_o[BIT_EN2]   != prev_q[BIT_EN2],
                ctrl_o[BIT_CKOFF] != prev_q[BIT_CKOFF],
                ctrl_o[CW-1:PDN_LSB] != prev_q[CW-1:PDN_LSB]};

  // R10
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $countones(chg) <= 1);
  // R10
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7:5] == 3'b000);
  // R3
  clk_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[BIT_CKOFF]) |-> $past(pwr_ack_i && pwr_ack2_i) && ctrl_o[BIT_EN1] && ctrl_o[BIT_EN2]);
  // R4
  iso_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[BIT_ISO]) |-> !ctrl_o[BIT_CKOFF]);
  // R4
  rst_after_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[BIT_RSTN]) |-> !ctrl_o[BIT_ISO]);
  // R4
  sram_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && prev_q[CW-1:PDN_LSB] != '0 && ctrl_o[CW-1:PDN_LSB] == '0) |-> ctrl_o[BIT_RSTN]);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  generate
    if (ACK_MASK != '0) begin : g_sram_chk
      // R5
      done_sram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past((sram_ack_i & ACK_MASK) == '0));
    end
  endgenerate
endmodule

bind pwr_island_seq pwr_island_seq_chk #(
  .SRAM_W(SRAM_W), .ACK_W(ACK_W), .ACK_MASK(ACK_MASK)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_ack_i  (pwr_ack_i),
  .pwr_ack2_i (pwr_ack2_i),
  .sram_ack_i (sram_ack_i),
  .ctrl_o     (ctrl_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_pwr_island_seq.sv
`timescale 1ns/1ps
module test_pwr_island_seq;
  localparam int SW = 4, AW = 4, TW = 8, CW = 8 + SW;
  localparam logic [CW-1:0] W_RST = 12'hF12, W_EN1 = 12'hF16, W_EN2 = 12'hF1E,
                            W_CK = 12'hF0E, W_ISO = 12'hF0C, W_RSTN = 12'hF0D, W_ON = 12'h00D;
  localparam logic [3:0] K_WORD = 4'd0, K_DONE = 4'd1, K_ERR = 4'd2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start = 1'b0, start_s = 1'b0;
  logic [TW-1:0] budget = 8'd20;
  logic pwr_ack = 1'b0, pwr_ack2 = 1'b0;
  logic [AW-1:0] sram_ack = 4'hF;
  logic [CW-1:0] ctrl, status, ctrl_s, status_s;
  logic done, err, done_s, err_s;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  logic [CW-1:0] prev;

  always #5 clk_i = ~clk_i;

  pwr_island_seq #(.SRAM_W(SW), .ACK_W(AW), .ACK_MASK(4'b1011), .TMO_W(TW)) i_pwr_island_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .budget_i(budget),
    .pwr_ack_i(pwr_ack), .pwr_ack2_i(pwr_ack2), .sram_ack_i(sram_ack),
    .ctrl_o(ctrl), .status_o(status), .done_o(done), .err_o(err));

  pwr_island_seq #(.SRAM_W(SW), .ACK_W(AW), .ACK_MASK(4'b0000), .TMO_W(TW)) i_pwr_island_seq_skip (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_s), .budget_i(budget),
    .pwr_ack_i(pwr_ack), .pwr_ack2_i(pwr_ack2), .sram_ack_i(sram_ack),
    .ctrl_o(ctrl_s), .status_o(status_s), .done_o(done_s), .err_o(err_s));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] k, input logic [CW-1:0] w);
    exp_q.push_back({k, w});
  endtask

  task automatic push_full();
    push(K_WORD, W_EN1); push(K_WORD, W_EN2); push(K_WORD, W_CK);
    push(K_WORD, W_ISO); push(K_WORD, W_RSTN); push(K_WORD, W_ON);
  endtask

  task automatic sb_pop(input logic [15:0] got);
    logic [15:0] e;
    if (exp_q.size() == 0) check(1'b0, "R2 R4 R8 unexpected event", int'(got), 0);
    else begin
      e = exp_q.pop_front();
      check(got == e, "R2 R3 R4 R7 R9 sequence", int'(got), int'(e));
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (!rst_ni) prev = ctrl;
    else begin
      if (ctrl !== prev) begin
        sb_pop({K_WORD, ctrl});
        check(status === ctrl, "R10 status mirror", int'(status), int'(ctrl));
        prev = ctrl;
      end
      if (done) sb_pop({K_DONE, {CW{1'b0}}});
      if (err)  sb_pop({K_ERR, {CW{1'b0}}});
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; start = 1'b0; start_s = 1'b0;
    pwr_ack = 1'b0; pwr_ack2 = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // counts edges from the start edge up to the done/err sample
  task automatic measure(input bit skip, output int n, output bit got_done, output bit got_err);
    n = 0; got_done = 0; got_err = 0;
    if (skip) start_s = 1'b1; else start = 1'b1;
    while (n < 200) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      start = 1'b0; start_s = 1'b0;
      if (skip ? (done_s || err_s) : (done || err)) begin
        got_done = skip ? done_s : done;
        got_err  = skip ? err_s : err;
        break;
      end
    end
  endtask

  task automatic drain(input string req);
    repeat (6) @(negedge clk_i);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(20000 * 10);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n; bit d, e;
    do_reset();
    // R1
    check(ctrl == W_RST, "R1 reset word", int'(ctrl), int'(W_RST));
    check(status == W_RST, "R1 status reset", int'(status), int'(W_RST));
    check(!done && !err, "R1 pulses low", int'({done, err}), 0);

    // S1: staggered acks, mid-run start, SRAM ack outside mask
    push_full(); push(K_DONE, '0);
    @(negedge clk_i);
    fork
      measure(1'b0, n, d, e);
      begin
        repeat (4) @(negedge clk_i); pwr_ack = 1'b1;
        repeat (2) @(negedge clk_i);
        start = 1'b1; @(negedge clk_i); start = 1'b0;   // R8
        check(ctrl == W_EN2, "R3 single ack holds", int'(ctrl), int'(W_EN2));
        pwr_ack2 = 1'b1;
        repeat (8) @(negedge clk_i);
        check(!done, "R5 no done with masked ack high", int'(done), 0);
        sram_ack = 4'b0100;
      end
    join
    check(d && !e, "R5 done after SRAM ack", int'({d, e}), 2);
    drain("R8 no extra events");
    check(ctrl == W_ON, "R4 final word", int'(ctrl), int'(W_ON));

    // S2: restart after done
    push(K_DONE, '0);
    @(negedge clk_i);
    measure(1'b0, n, d, e);
    check(d && n == 7, "R9 restart done edges", n, 7);
    drain("R9 restart events");

    // S3: power-wait timeout
    do_reset(); budget = 8'd5; sram_ack = 4'h0;
    push(K_WORD, W_EN1); push(K_WORD, W_EN2); push(K_ERR, '0);
    measure(1'b0, n, d, e);
    check(e && n == 8, "R7 power timeout edges", n, 8);
    drain("R7 frozen after error");
    check(ctrl == W_EN2, "R7 word frozen", int'(ctrl), int'(W_EN2));

    // S4: resume after error
    pwr_ack = 1'b1; pwr_ack2 = 1'b1;
    push(K_WORD, W_CK); push(K_WORD, W_ISO); push(K_WORD, W_RSTN); push(K_WORD, W_ON); push(K_DONE, '0);
    measure(1'b0, n, d, e);
    check(d && n == 7, "R9 resume after error", n, 7);
    drain("R9 resume events");

    // S5: ack at last allowed check
    do_reset(); budget = 8'd4;
    push_full(); push(K_DONE, '0);
    fork
      measure(1'b0, n, d, e);
      begin repeat (6) @(negedge clk_i); pwr_ack = 1'b1; pwr_ack2 = 1'b1; end
    join
    check(d && n == 11, "R7 boundary success", n, 11);
    drain("R7 boundary events");

    // S6: ack one cycle too late
    do_reset();
    push(K_WORD, W_EN1); push(K_WORD, W_EN2); push(K_ERR, '0);
    fork
      measure(1'b0, n, d, e);
      begin repeat (7) @(negedge clk_i); pwr_ack = 1'b1; pwr_ack2 = 1'b1; end
    join
    check(e && n == 7, "R7 boundary timeout", n, 7);
    drain("R7 late events");

    // S7: SRAM-wait timeout
    do_reset(); budget = 8'd3; sram_ack = 4'b0001;
    pwr_ack = 1'b1; pwr_ack2 = 1'b1;
    push_full(); push(K_ERR, '0);
    measure(1'b0, n, d, e);
    check(e && n == 10, "R5 R7 SRAM timeout", n, 10);
    drain("R7 SRAM timeout events");

    // S8: empty mask skips SRAM wait
    do_reset(); budget = 8'd20; sram_ack = 4'hF;
    pwr_ack = 1'b1; pwr_ack2 = 1'b1;
    measure(1'b1, n, d, e);
    check(d && n == 6, "R6 skip done edges", n, 6);
    check(ctrl_s == W_ON && status_s == W_ON, "R6 skip final word", int'(ctrl_s), int'(W_ON));
    drain("R6 main idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule